// File: doc/BRIEF.md
# USB Device Link Power Manager

This block tracks the connection and power state of a USB device controller that runs in the peripheral role. It decides whether the PHY should be connected, enters a suspended state after a stretch of bus silence, and leaves it either on resume signalling from the host or through a software-started remote wakeup. When a bus reset is seen, it issues the clearing strobes that the rest of the controller needs. It also drives interrupt pulses and keeps a read-to-clear interrupt status register.

Software controls the block through three small registers. The control register holds connect, wakeup and high-speed-enable bits. The enable register holds one enable bit per interrupt. The status register latches the interrupts that have fired. Line-level decoding is done elsewhere and arrives here as an activity strobe and as resume and reset event inputs. Time is measured with a millisecond tick, which is divided down from the clock by a parameter. A small divider therefore gives short timeouts in simulation.

Top module: `usb_link_pwr`

## Requirements
- R1: `periph_o` is 1 exactly when `id_float_i` is 1, or when both `id_ovr_en_i` and `id_ovr_val_i` are 1. It is combinational.
- R2: After reset, `ctl_o`, `ie_o` and `stat_o` are 0, and `phy_conn_o`, `suspended_o` and `resume_drv_o` are 0. `phy_conn_o` equals control bit 0 (connect) ANDed with `periph_o`. When `phy_conn_o` is 0, the link returns to the idle disconnected state at the next clock.
- R3: While connected and not suspended, `suspended_o` rises exactly IDLE_MS*CLKS_PER_MS clocks after the clock edge that sampled the last `bus_act_i` pulse. Every activity pulse restarts this count.
- R4: On entry to suspend, `irq_suspend_o` pulses for one clock and status bit 0 is set, but only if enable bit 0 is 1.
- R5: While suspended (and not waking), a `line_resume_i` pulse clears `suspended_o` at the next edge. In the same clock, `irq_resume_o` pulses and status bit 1 is set, but only if enable bit 1 is 1.
- R6: When control bit 1 (wakeup) is set while suspended, `resume_drv_o` is 1 from the second edge after the write for as long as the bit stays set. Meanwhile `suspended_o` stays 1 and `line_resume_i` is ignored. Clearing the bit ends the wakeup one clock after the write, and no resume interrupt is raised for it.
- R7: A rising edge on `line_reset_i` while connected gives one-clock pulses on `faddr_clr_o`, `index_clr_o`, `fifo_flush_o` and `irq_reset_o`, even if the line is held high. It also clears control bit 1, sets `ie_o` to 3'b111 and sets `stat_o` to 3'b100 (status bit 2 = reset).
- R8: `hs_neg_req_o` pulses together with the reset strobes only when control bit 2 is 1. `hs_mode_o` takes `hs_ok_i` when `hs_done_i` is 1, and is cleared by a bus reset.
- R9: When a wakeup ends by clearing the wakeup bit, `wake_bad_o` is set to 1 if fewer than WAKE_MIN_MS or more than WAKE_MAX_MS millisecond ticks passed during it, and to 0 otherwise. A bus reset clears it.
- R10: A bus reset has priority over a resume event or an idle timeout in the same clock. The link ends up not suspended, with `irq_reset_o` set and neither `irq_suspend_o` nor `irq_resume_o` set.
- R11: Pulsing `stat_rd_i` clears `stat_o` at that edge. An interrupt that is latched in the same clock still sets its bit.
- R12: While disconnected, line reset and resume events produce no strobes and no interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on or soft reset |
| id_float_i | input | 1 | ID input is floating |
| id_ovr_en_i | input | 1 | Enable the role override |
| id_ovr_val_i | input | 1 | Role override value (1 = peripheral) |
| bus_act_i | input | 1 | Bus activity strobe |
| line_resume_i | input | 1 | Resume signalling detected |
| line_reset_i | input | 1 | Bus reset condition detected |
| ctl_wr_i | input | 1 | Write the control register |
| ctl_wdata_i | input | 3 | Control data: bit0 connect, bit1 wakeup, bit2 high-speed enable |
| ie_wr_i | input | 1 | Write the interrupt enable register |
| ie_wdata_i | input | 3 | Enable data: bit0 suspend, bit1 resume, bit2 reset |
| stat_rd_i | input | 1 | Read strobe; clears the status register |
| hs_done_i | input | 1 | High-speed negotiation finished |
| hs_ok_i | input | 1 | High-speed negotiation succeeded |
| periph_o | output | 1 | Peripheral role selected |
| ctl_o | output | 3 | Control register contents |
| ie_o | output | 3 | Interrupt enable register contents |
| stat_o | output | 3 | Latched interrupt status (same bit order as enable) |
| hs_mode_o | output | 1 | High-speed mode in use |
| wake_bad_o | output | 1 | Last wakeup was outside the allowed window |
| phy_conn_o | output | 1 | PHY connect enable |
| suspended_o | output | 1 | Link is suspended |
| resume_drv_o | output | 1 | Drive resume signalling on the bus |
| irq_suspend_o | output | 1 | Suspend interrupt pulse |
| irq_resume_o | output | 1 | Resume interrupt pulse |
| irq_reset_o | output | 1 | Bus reset interrupt pulse |
| fifo_flush_o | output | 1 | Flush all endpoint FIFOs |
| faddr_clr_o | output | 1 | Clear the function address |
| index_clr_o | output | 1 | Clear the index register |
| hs_neg_req_o | output | 1 | Request high-speed negotiation |

## Verification
The idle timer is driven with activity pulses at random gaps, all shorter than the timeout. This shows whether each pulse really restarts the count. A final silent stretch is then sampled one clock before and one clock at the expected suspend edge, which exposes off-by-one errors in the divider or the millisecond counter.

Wakeups held for a short, a normal and a long time separate the lower and upper bounds of the window check. Bus resets are placed in the same cycle as a resume event, in the exact cycle of an idle timeout, and as a line held high. These cases show priority, edge detection and the single-clock width of the strobes.

Random role inputs check the role and connect decoding.

// File: rtl/usb_lpm_pkg.sv
package usb_lpm_pkg;
   typedef enum logic [1:0] {
      LS_OFF  = 2'd0,
      LS_ON   = 2'd1,
      LS_SUSP = 2'd2,
      LS_WAKE = 2'd3
   } link_st_e;

   localparam int CTL_CONN = 0;
   localparam int CTL_WAKE = 1;
   localparam int CTL_HSEN = 2;

   localparam int IRQ_SUSP = 0;
   localparam int IRQ_RES  = 1;
   localparam int IRQ_RST  = 2;
endpackage

// File: rtl/usb_lpm_ms_tick.sv
module usb_lpm_ms_tick #(
   parameter int CLKS_PER_MS = 60000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (CLKS_PER_MS > 2) ? $clog2(CLKS_PER_MS) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

   generate
      if (CLKS_PER_MS < 2) begin : g_bad_div
         $error("usb_lpm_ms_tick: CLKS_PER_MS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = !clr && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr || tick)    cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // A tick is never followed by another one in the next clock (R3).
   assert_tick_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/usb_lpm_idle_timer.sv
module usb_lpm_idle_timer #(
   parameter int CLKS_PER_MS = 60000,
   parameter int IDLE_MS     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic act,
   output logic timeout
);
   localparam int MW = $clog2(IDLE_MS + 1);
   localparam logic [MW-1:0] MS_LAST = MW'(IDLE_MS - 1);

   generate
      if (IDLE_MS < 1) begin : g_bad_idle
         $error("usb_lpm_idle_timer: IDLE_MS must be at least 1");
      end
   endgenerate

   logic          clr;
   logic          ms_tick;
   logic [MW-1:0] ms_q;

   assign clr = !run || act;

   usb_lpm_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .tick (ms_tick)
   );

   assign timeout = ms_tick && (ms_q == MS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ms_q <= '0;
      else if (clr)        ms_q <= '0;
      else if (ms_tick)    ms_q <= timeout ? '0 : ms_q + 1'b1;
   end

   // The millisecond count never passes the timeout value (R3).
   assert_ms_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ms_q <= MS_LAST);
endmodule

// File: rtl/usb_lpm_wake_window.sv
module usb_lpm_wake_window #(
   parameter int CLKS_PER_MS = 60000,
   parameter int MIN_MS      = 2,
   parameter int MAX_MS      = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic done,
   input  logic clr_flag,
   output logic bad
);
   localparam int CW = $clog2(MAX_MS + 2);
   localparam logic [CW-1:0] SAT = CW'(MAX_MS + 1);
   localparam logic [CW-1:0] LO  = CW'(MIN_MS);
   localparam logic [CW-1:0] HI  = CW'(MAX_MS);

   generate
      if (MIN_MS > MAX_MS) begin : g_bad_window
         $error("usb_lpm_wake_window: MIN_MS must not exceed MAX_MS");
      end
   endgenerate

   logic          ms_tick;
   logic [CW-1:0] cnt_q;
   logic          bad_q;

   usb_lpm_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!active),
      .tick (ms_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (!active)                   cnt_q <= '0;
      else if (ms_tick && cnt_q != SAT)   cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bad_q <= 1'b0;
      else if (clr_flag)  bad_q <= 1'b0;
      else if (done)      bad_q <= (cnt_q < LO) || (cnt_q > HI);
   end

   assign bad = bad_q;

   // The held-time count saturates one above the upper bound (R9).
   assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= SAT);
endmodule

// File: rtl/usb_link_pwr.sv
module usb_link_pwr
   import usb_lpm_pkg::*;
#(
   parameter int CLKS_PER_MS = 60000,
   parameter int IDLE_MS     = 3,
   parameter int WAKE_MIN_MS = 2,
   parameter int WAKE_MAX_MS = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       id_float_i,
   input  logic       id_ovr_en_i,
   input  logic       id_ovr_val_i,
   input  logic       bus_act_i,
   input  logic       line_resume_i,
   input  logic       line_reset_i,
   input  logic       ctl_wr_i,
   input  logic [2:0] ctl_wdata_i,
   input  logic       ie_wr_i,
   input  logic [2:0] ie_wdata_i,
   input  logic       stat_rd_i,
   input  logic       hs_done_i,
   input  logic       hs_ok_i,
   output logic       periph_o,
   output logic [2:0] ctl_o,
   output logic [2:0] ie_o,
   output logic [2:0] stat_o,
   output logic       hs_mode_o,
   output logic       wake_bad_o,
   output logic       phy_conn_o,
   output logic       suspended_o,
   output logic       resume_drv_o,
   output logic       irq_suspend_o,
   output logic       irq_resume_o,
   output logic       irq_reset_o,
   output logic       fifo_flush_o,
   output logic       faddr_clr_o,
   output logic       index_clr_o,
   output logic       hs_neg_req_o
);
   link_st_e   st_q, st_d;
   logic [2:0] ctl_q, ie_q, stat_q, stat_set;
   logic       rst_d_q, hs_mode_q;
   logic       periph, conn, rst_ev, timeout;
   logic       ev_susp, ev_res, wake_done;
   logic       irq_susp_q, irq_res_q, irq_rst_q, hs_req_q;

   assign periph = id_float_i || (id_ovr_en_i && id_ovr_val_i);
   assign conn   = ctl_q[CTL_CONN] && periph;
   assign rst_ev = conn && line_reset_i && !rst_d_q;

   usb_lpm_idle_timer #(.CLKS_PER_MS(CLKS_PER_MS), .IDLE_MS(IDLE_MS)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (conn && st_q == LS_ON),
      .act    (bus_act_i || line_reset_i),
      .timeout(timeout)
   );

   usb_lpm_wake_window #(
      .CLKS_PER_MS(CLKS_PER_MS), .MIN_MS(WAKE_MIN_MS), .MAX_MS(WAKE_MAX_MS)
   ) u_wake (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (st_q == LS_WAKE),
      .done    (wake_done),
      .clr_flag(rst_ev),
      .bad     (wake_bad_o)
   );

   assign ev_susp   = conn && !rst_ev && st_q == LS_ON   && timeout;
   assign ev_res    = conn && !rst_ev && st_q == LS_SUSP && line_resume_i;
   assign wake_done = conn && !rst_ev && st_q == LS_WAKE && !ctl_q[CTL_WAKE];
   assign stat_set  = {1'b0, ev_res && ie_q[IRQ_RES], ev_susp && ie_q[IRQ_SUSP]};

   always_comb begin
      st_d = st_q;
      if (!conn)        st_d = LS_OFF;
      else if (rst_ev)  st_d = LS_ON;
      else begin
         case (st_q)
            LS_OFF:  st_d = LS_ON;
            LS_ON:   if (timeout) st_d = LS_SUSP;
            LS_SUSP: if (line_resume_i)         st_d = LS_ON;
                     else if (ctl_q[CTL_WAKE])  st_d = LS_WAKE;
            LS_WAKE: if (!ctl_q[CTL_WAKE])      st_d = LS_ON;
            default: st_d = LS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= LS_OFF;
         rst_d_q    <= 1'b0;
         ctl_q      <= '0;
         ie_q       <= '0;
         stat_q     <= '0;
         hs_mode_q  <= 1'b0;
         irq_susp_q <= 1'b0;
         irq_res_q  <= 1'b0;
         irq_rst_q  <= 1'b0;
         hs_req_q   <= 1'b0;
      end else begin
         st_q       <= st_d;
         rst_d_q    <= line_reset_i;
         irq_susp_q <= stat_set[IRQ_SUSP];
         irq_res_q  <= stat_set[IRQ_RES];
         irq_rst_q  <= rst_ev;
         hs_req_q   <= rst_ev && ctl_q[CTL_HSEN];
         if (ctl_wr_i) ctl_q <= ctl_wdata_i;
         if (rst_ev) begin
            ctl_q[CTL_WAKE] <= 1'b0;
            ie_q            <= '1;
            stat_q          <= 3'b100;
            hs_mode_q       <= 1'b0;
         end else begin
            if (ie_wr_i)   ie_q <= ie_wdata_i;
            stat_q <= (stat_rd_i ? 3'b000 : stat_q) | stat_set;
            if (hs_done_i) hs_mode_q <= hs_ok_i;
         end
      end
   end

   assign periph_o      = periph;
   assign ctl_o         = ctl_q;
   assign ie_o          = ie_q;
   assign stat_o        = stat_q;
   assign hs_mode_o     = hs_mode_q;
   assign phy_conn_o    = conn;
   assign suspended_o   = (st_q == LS_SUSP) || (st_q == LS_WAKE);
   assign resume_drv_o  = (st_q == LS_WAKE);
   assign irq_suspend_o = irq_susp_q;
   assign irq_resume_o  = irq_res_q;
   assign irq_reset_o   = irq_rst_q;
   assign fifo_flush_o  = irq_rst_q;
   assign faddr_clr_o   = irq_rst_q;
   assign index_clr_o   = irq_rst_q;
   assign hs_neg_req_o  = hs_req_q;

   // A dropped connection leaves the link idle one clock later (R2).
   assert_conn_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_conn_o |=> (st_q == LS_OFF));

   // A suspend interrupt needs the enable as it was before the edge (R4).
   assert_susp_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_suspend_o |-> $past(ie_q[IRQ_SUSP]));

   // No resume interrupt comes out of a software wakeup (R6).
   assert_wake_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LS_WAKE) |=> !irq_resume_o);

   // The clearing strobes last exactly one clock (R7).
   assert_clr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      faddr_clr_o |=> !faddr_clr_o);

   // The negotiation request only goes out with a bus reset (R8).
   assert_hs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hs_neg_req_o |-> irq_reset_o);

   // A reset wins over resume and timeout in the same clock (R10).
   assert_rst_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ev |=> (irq_reset_o && !irq_suspend_o && !irq_resume_o && !suspended_o));
endmodule

// File: tb/usb_link_pwr_test.sv
module usb_link_pwr_test;
   localparam int CLK_PERIOD = 10;
   localparam int MS         = 20;
   localparam int IDLE       = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       id_float_i = 0, id_ovr_en_i = 0, id_ovr_val_i = 0;
   logic       bus_act_i = 0, line_resume_i = 0, line_reset_i = 0;
   logic       ctl_wr_i = 0, ie_wr_i = 0, stat_rd_i = 0, hs_done_i = 0, hs_ok_i = 0;
   logic [2:0] ctl_wdata_i = '0, ie_wdata_i = '0;
   logic       periph_o, hs_mode_o, wake_bad_o, phy_conn_o, suspended_o, resume_drv_o;
   logic [2:0] ctl_o, ie_o, stat_o;
   logic       irq_suspend_o, irq_resume_o, irq_reset_o;
   logic       fifo_flush_o, faddr_clr_o, index_clr_o, hs_neg_req_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_link_pwr #(.CLKS_PER_MS(MS), .IDLE_MS(IDLE), .WAKE_MIN_MS(2), .WAKE_MAX_MS(15)) uut (
      .clk(clk), .rst_n(rst_n),
      .id_float_i(id_float_i), .id_ovr_en_i(id_ovr_en_i), .id_ovr_val_i(id_ovr_val_i),
      .bus_act_i(bus_act_i), .line_resume_i(line_resume_i), .line_reset_i(line_reset_i),
      .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .ie_wr_i(ie_wr_i), .ie_wdata_i(ie_wdata_i),
      .stat_rd_i(stat_rd_i), .hs_done_i(hs_done_i), .hs_ok_i(hs_ok_i),
      .periph_o(periph_o), .ctl_o(ctl_o), .ie_o(ie_o), .stat_o(stat_o),
      .hs_mode_o(hs_mode_o), .wake_bad_o(wake_bad_o), .phy_conn_o(phy_conn_o),
      .suspended_o(suspended_o), .resume_drv_o(resume_drv_o),
      .irq_suspend_o(irq_suspend_o), .irq_resume_o(irq_resume_o), .irq_reset_o(irq_reset_o),
      .fifo_flush_o(fifo_flush_o), .faddr_clr_o(faddr_clr_o), .index_clr_o(index_clr_o),
      .hs_neg_req_o(hs_neg_req_o)
   );

   function automatic logic exp_role(logic f, logic en, logic v);
      return f | (en & v);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr_ctl(logic [2:0] v);
      ctl_wr_i = 1; ctl_wdata_i = v; step(); ctl_wr_i = 0;
   endtask

   task automatic wr_ie(logic [2:0] v);
      ie_wr_i = 1; ie_wdata_i = v; step(); ie_wr_i = 0;
   endtask

   task automatic rd_stat();
      stat_rd_i = 1; step(); stat_rd_i = 0;
   endtask

   task automatic wait_susp();
      for (int i = 0; i < 5*IDLE*MS && !suspended_o; i++) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      bit seen;
      void'($urandom(32'h5eed_0042));
      steps(3);
      rst_n = 1;
      step();
      // R2: reset state
      chk("R2 reset ctl", ctl_o, 0);
      chk("R2 reset ie", ie_o, 0);
      chk("R2 reset stat", stat_o, 0);
      chk("R2 reset conn/susp/drv", {phy_conn_o, suspended_o, resume_drv_o}, 0);

      // R1: random role inputs, connect bit still 0
      for (int i = 0; i < 16; i++) begin
         logic [2:0] r = 3'($urandom);
         {id_float_i, id_ovr_en_i, id_ovr_val_i} = r;
         #1;
         chk("R1 role", periph_o, exp_role(r[2], r[1], r[0]));
         chk("R2 no conn without bit", phy_conn_o, 0);
      end
      {id_float_i, id_ovr_en_i, id_ovr_val_i} = 3'b011;
      wr_ctl(3'b001);
      chk("R2 connect via override", phy_conn_o, 1);
      id_ovr_val_i = 0; #1;
      chk("R1 override off disconnects", phy_conn_o, 0);
      id_float_i = 1; #1;
      step();
      wr_ie(3'b011);
      chk("R4 ie write", ie_o, 3'b011);

      // R3: random activity gaps keep the link awake
      seen = 0;
      for (int k = 0; k < 25; k++) begin
         int gap = 1 + int'($urandom % (IDLE*MS - 4));
         bus_act_i = 1; step(); bus_act_i = 0;
         for (int j = 0; j < gap; j++) begin
            if (suspended_o) seen = 1;
            step();
         end
      end
      chk("R3 activity restarts timer", seen, 0);
      bus_act_i = 1; step(); bus_act_i = 0;
      steps(IDLE*MS - 1);
      chk("R3 not yet suspended", suspended_o, 0);
      step();
      chk("R3 suspend at timeout", suspended_o, 1);
      chk("R4 suspend irq enabled", irq_suspend_o, 1);
      chk("R4 suspend status", stat_o[0], 1);
      step();
      chk("R4 irq single pulse", irq_suspend_o, 0);

      // R11: read clears; R5 resume, read in same clock keeps new bit
      rd_stat();
      chk("R11 read clears", stat_o, 0);
      line_resume_i = 1; stat_rd_i = 1; step(); line_resume_i = 0; stat_rd_i = 0;
      chk("R5 resume exits", suspended_o, 0);
      chk("R5 resume irq", irq_resume_o, 1);
      chk("R11 new bit wins over read", stat_o, 3'b010);

      // R4: suspend interrupt disabled
      wr_ie(3'b010);
      rd_stat();
      seen = 0;
      for (int i = 0; i < 5*IDLE*MS && !suspended_o; i++) begin
         step();
         if (irq_suspend_o) seen = 1;
      end
      chk("R4 suspended", suspended_o, 1);
      chk("R4 no irq when disabled", {seen, stat_o[0]}, 0);
      // R5: resume interrupt disabled
      wr_ie(3'b000);
      line_resume_i = 1; step(); line_resume_i = 0;
      chk("R5 exit without irq", {suspended_o, irq_resume_o, stat_o[1]}, 0);

      // R6 / R9: remote wakeup of normal length
      wr_ie(3'b111);
      wait_susp();
      rd_stat();
      wr_ctl(3'b011);
      step();
      chk("R6 drive resume", {resume_drv_o, suspended_o}, 2'b11);
      seen = 0;
      for (int i = 0; i < 5*MS; i++) begin
         line_resume_i = (i % 7 == 3);
         step();
         if (irq_resume_o || !resume_drv_o) seen = 1;
      end
      line_resume_i = 0;
      chk("R6 held while bit set", seen, 0);
      wr_ctl(3'b001);
      step();
      chk("R6 wakeup ends", {resume_drv_o, suspended_o, irq_resume_o}, 0);
      chk("R6 no resume status", stat_o[1], 0);
      chk("R9 normal wakeup ok", wake_bad_o, 0);

      // R9: short and long wakeups
      wait_susp();
      wr_ctl(3'b011); steps(MS/2); wr_ctl(3'b001); step();
      chk("R9 short wakeup flagged", wake_bad_o, 1);
      wait_susp();
      wr_ctl(3'b011); steps(5*MS); wr_ctl(3'b001); step();
      chk("R9 flag cleared by good wakeup", wake_bad_o, 0);
      wait_susp();
      wr_ctl(3'b011); steps(20*MS); wr_ctl(3'b001); step();
      chk("R9 long wakeup flagged", wake_bad_o, 1);

      // R10 / R7 / R8: reset with resume in the same clock while suspended
      wait_susp();
      wr_ie(3'b000);
      wr_ctl(3'b101);
      line_reset_i = 1; line_resume_i = 1; step(); line_reset_i = 0; line_resume_i = 0;
      chk("R10 reset over resume", {suspended_o, irq_reset_o, irq_resume_o}, 3'b010);
      chk("R7 clear strobes", {faddr_clr_o, index_clr_o, fifo_flush_o}, 3'b111);
      chk("R7 enables all", ie_o, 3'b111);
      chk("R7 status reset bit", stat_o, 3'b100);
      chk("R8 hs request", hs_neg_req_o, 1);
      chk("R9 flag cleared by reset", wake_bad_o, 0);
      step();
      chk("R7 strobes one clock", {faddr_clr_o, irq_reset_o, hs_neg_req_o}, 0);

      // R7: held reset line, wakeup bit cleared
      wr_ctl(3'b111);
      step();
      chk("R6 wakeup ignored when awake", resume_drv_o, 0);
      line_reset_i = 1; step();
      chk("R7 held reset first pulse", {faddr_clr_o, index_clr_o, fifo_flush_o, irq_reset_o}, 4'hf);
      chk("R7 wakeup bit cleared", ctl_o, 3'b101);
      step();
      chk("R7 held reset no second pulse", {faddr_clr_o, irq_reset_o}, 0);
      step(); line_reset_i = 0; step();

      // R10: reset in the exact timeout clock
      bus_act_i = 1; step(); bus_act_i = 0;
      steps(IDLE*MS - 1);
      line_reset_i = 1; step(); line_reset_i = 0;
      chk("R10 reset over timeout", {suspended_o, irq_reset_o, irq_suspend_o}, 3'b010);

      // R8: negotiation result and clear
      hs_done_i = 1; hs_ok_i = 1; step(); hs_done_i = 0; hs_ok_i = 0;
      chk("R8 hs mode set", hs_mode_o, 1);
      wr_ctl(3'b001);
      line_reset_i = 1; step(); line_reset_i = 0;
      chk("R8 no request without enable", hs_neg_req_o, 0);
      chk("R8 hs mode cleared", hs_mode_o, 0);

      // R2 / R12: disconnect
      wait_susp();
      wr_ctl(3'b000);
      chk("R2 disconnect", phy_conn_o, 0);
      step();
      chk("R2 idle after disconnect", {suspended_o, resume_drv_o}, 0);
      line_reset_i = 1; line_resume_i = 1; step(); line_reset_i = 0; line_resume_i = 0;
      chk("R12 no strobes while off", {irq_reset_o, fifo_flush_o, faddr_clr_o, irq_resume_o}, 0);
      chk("R12 ie untouched", ie_o, 3'b111);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule